// File: doc/BRIEF.md
# Per-Processor Interrupt Acknowledge Port

This block sits between an interrupt distributor and one processor. The distributor offers the block its single best pending interrupt: a valid flag, a 10-bit identifier and an 8-bit priority. The block decides whether that candidate may interrupt the processor, and drives a registered request line. A per-port enable bit and a priority threshold gate that decision. The block also refuses identifiers it already holds as active, and it refuses everything once its active table is full.

Software reaches the block through a small word-addressed register bus. It provides an enable register, a priority threshold register, an acknowledge register and a completion register. Reading the acknowledge register is destructive. It returns the identifier offered in the cycle of the read strobe and records that identifier as active. It also pulses a claim toward the distributor so that the interrupt moves from pending to active. When nothing qualifies, the read returns the reserved "nothing here" identifier 1023 and changes no state. Writing an identifier to the completion register retires it and pulses a release toward the distributor. The block is parameterised in the number of interrupts it can hold active at once and in its address width.

Top module: `cpu_irq_port`

## Requirements
- R1: An acknowledge read (bus_en=1, bus_we=0, bus_addr=2) returns, one cycle later on bus_rdata, the identifier offered in the strobe cycle in bits [9:0], with bits [31:10] zero. A change of the offered identifier after the strobe cycle does not alter the returned value.
- R2: An acknowledge read while no candidate qualifies returns 1023 on bus_rdata[9:0] and raises no claim pulse.
- R3: Bit 0 of the enable register (offset 0) turns signalling on. While it is 0, irq_out stays low and acknowledge reads return 1023. The other bits of that register do not enable anything.
- R4: A candidate qualifies only when its priority is numerically below the threshold held in bits [7:0] of offset 1. Equal priority does not qualify.
- R5: Offered identifiers 1021, 1022 and 1023 never qualify. Identifiers 0 to 1020 may qualify.
- R6: A successful acknowledge raises claim_valid for exactly one cycle, in the cycle bus_rdata shows the result, with claim_id equal to the returned identifier.
- R7: An identifier taken by an acknowledge is active and does not qualify again until it is completed.
- R8: A write of an active identifier to offset 3 (identifier in bus_wdata[9:0]) raises release_valid with release_id equal to that identifier for one cycle, the next cycle. The identifier may then qualify again.
- R9: A completion write naming an identifier that is not active raises no release pulse and leaves the active set unchanged.
- R10: While ACT_SLOTS identifiers are active, nothing qualifies. Completing any one of them frees room for a new acknowledge.
- R11: irq_out is registered: in each cycle it shows whether the candidate qualified at the previous clock edge.
- R12: Reading offsets 0 and 1 returns the enable bit and the threshold one cycle after the strobe. Both reset to 0, so after reset nothing is signalled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cand_valid | input | 1 | Distributor offers a candidate |
| cand_id | input | 10 | Identifier of the offered candidate |
| cand_prio | input | 8 | Priority of the offered candidate, lower is more urgent |
| bus_en | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 for write, 0 for read |
| bus_addr | input | ADDR_W | Word offset: 0 enable, 1 threshold, 2 acknowledge, 3 completion |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after a read strobe |
| irq_out | output | 1 | Interrupt request to the processor |
| claim_valid | output | 1 | Pulse: move claim_id from pending to active |
| claim_id | output | 10 | Identifier being claimed |
| release_valid | output | 1 | Pulse: clear the active state of release_id |
| release_id | output | 10 | Identifier being released |

## Verification
The properties assume the bus issues at most one access per cycle. They also assume the candidate inputs and bus inputs are held at zero during reset, because the checks look one cycle back at the strobe and the offered priority. The stimulus drives every input at the falling edge and keeps one access in each cycle. It draws identifiers from a small pool, so that repeats, completions of active identifiers and a full active table all occur. Reserved identifiers are offered on purpose to confirm that they are refused.

// File: rtl/cirq_pkg.sv
package cirq_pkg;

    localparam int IRQ_ID_W = 10;
    localparam int PRIO_W   = 8;
    localparam int BUS_W    = 32;

    localparam int OFF_ENABLE  = 0;
    localparam int OFF_THRESH  = 1;
    localparam int OFF_ACK     = 2;
    localparam int OFF_RETIRE  = 3;

    typedef logic [IRQ_ID_W-1:0] irq_id_t;
    typedef logic [PRIO_W-1:0]   prio_t;

    localparam irq_id_t NONE_ID     = irq_id_t'(1023);
    localparam irq_id_t LAST_REAL_ID = irq_id_t'(1020);

    // decoded register access
    typedef enum logic [2:0] {
        ACC_IDLE,
        ACC_WR_ENABLE,
        ACC_WR_THRESH,
        ACC_WR_RETIRE,
        ACC_RD_ENABLE,
        ACC_RD_THRESH,
        ACC_RD_ACK,
        ACC_OTHER
    } access_e;

    typedef struct packed {
        logic    valid;
        irq_id_t id;
        prio_t   prio;
    } cand_t;

    function automatic logic id_is_real(irq_id_t id);
        return id <= LAST_REAL_ID;
    endfunction

endpackage

// File: rtl/cirq_ctrl_regs.sv
module cirq_ctrl_regs
    import cirq_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  enable_we,
    input  logic  thresh_we,
    input  logic  wr_enable_bit,
    input  prio_t wr_thresh,
    output logic  enable_q,
    output prio_t thresh_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            enable_q <= 1'b0;
            thresh_q <= '0;
        end else begin
            if (enable_we) enable_q <= wr_enable_bit;
            if (thresh_we) thresh_q <= wr_thresh;
        end
    end

endmodule

// File: rtl/cirq_active_set.sv
module cirq_active_set
    import cirq_pkg::*;
#(
    parameter int SLOTS = 4
) (
    input  logic    clk,
    input  logic    rst,
    input  irq_id_t probe_id,
    output logic    probe_hit,
    input  logic    claim_en,
    input  irq_id_t claim_id,
    input  logic    retire_en,
    input  irq_id_t retire_id,
    output logic    retire_hit,
    output logic    full
);

    logic [SLOTS-1:0] busy_q;
    irq_id_t          id_q [SLOTS];
    logic [SLOTS-1:0] probe_m;
    logic [SLOTS-1:0] retire_m;
    logic [SLOTS-1:0] free_oh;

    generate
        for (genvar g = 0; g < SLOTS; g++) begin : g_cmp
            assign probe_m[g]  = busy_q[g] && (id_q[g] == probe_id);
            assign retire_m[g] = busy_q[g] && (id_q[g] == retire_id);
        end
    endgenerate

    assign probe_hit  = |probe_m;
    assign retire_hit = |retire_m;
    assign full       = &busy_q;

    // lowest free slot, one-hot
    always_comb begin
        logic found;
        found   = 1'b0;
        free_oh = '0;
        for (int i = 0; i < SLOTS; i++) begin
            if (!busy_q[i] && !found) begin
                free_oh[i] = 1'b1;
                found      = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= '0;
            for (int i = 0; i < SLOTS; i++) id_q[i] <= '0;
        end else begin
            for (int i = 0; i < SLOTS; i++) begin
                if (retire_en && retire_m[i]) begin
                    busy_q[i] <= 1'b0;
                end else if (claim_en && free_oh[i]) begin
                    busy_q[i] <= 1'b1;
                    id_q[i]   <= claim_id;
                end
            end
        end
    end

endmodule

// File: rtl/cirq_qualify.sv
module cirq_qualify
    import cirq_pkg::*;
(
    input  cand_t cand,
    input  logic  enable,
    input  prio_t thresh,
    input  logic  already_active,
    input  logic  table_full,
    output logic  take
);

    always_comb begin
        take = enable
            && cand.valid
            && id_is_real(cand.id)
            && (cand.prio < thresh)
            && !already_active
            && !table_full;
    end

endmodule

// File: rtl/cpu_irq_port.sv
module cpu_irq_port
    import cirq_pkg::*;
#(
    parameter int ADDR_W    = 2,
    parameter int ACT_SLOTS = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cand_valid,
    input  logic [9:0]        cand_id,
    input  logic [7:0]        cand_prio,
    input  logic              bus_en,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              irq_out,
    output logic              claim_valid,
    output logic [9:0]        claim_id,
    output logic              release_valid,
    output logic [9:0]        release_id
);

    localparam logic [ADDR_W-1:0] A_ENABLE = ADDR_W'(OFF_ENABLE);
    localparam logic [ADDR_W-1:0] A_THRESH = ADDR_W'(OFF_THRESH);
    localparam logic [ADDR_W-1:0] A_ACK    = ADDR_W'(OFF_ACK);
    localparam logic [ADDR_W-1:0] A_RETIRE = ADDR_W'(OFF_RETIRE);

    cand_t   cand;
    access_e acc;
    logic    enable_q;
    prio_t   thresh_q;
    logic    probe_hit;
    logic    retire_hit;
    logic    slots_full;
    logic    take;
    irq_id_t wr_id;
    logic    unused_wdata;

    assign cand         = '{valid: cand_valid, id: cand_id, prio: cand_prio};
    assign wr_id        = bus_wdata[IRQ_ID_W-1:0];
    assign unused_wdata = ^bus_wdata[BUS_W-1:IRQ_ID_W];

    // bus decode
    always_comb begin
        acc = ACC_IDLE;
        if (bus_en) begin
            if (bus_we) begin
                unique case (bus_addr)
                    A_ENABLE: acc = ACC_WR_ENABLE;
                    A_THRESH: acc = ACC_WR_THRESH;
                    A_RETIRE: acc = ACC_WR_RETIRE;
                    default:  acc = ACC_OTHER;
                endcase
            end else begin
                unique case (bus_addr)
                    A_ENABLE: acc = ACC_RD_ENABLE;
                    A_THRESH: acc = ACC_RD_THRESH;
                    A_ACK:    acc = ACC_RD_ACK;
                    default:  acc = ACC_OTHER;
                endcase
            end
        end
    end

    cirq_ctrl_regs u_regs (
        .clk          (clk),
        .rst          (rst),
        .enable_we    (acc == ACC_WR_ENABLE),
        .thresh_we    (acc == ACC_WR_THRESH),
        .wr_enable_bit(bus_wdata[0]),
        .wr_thresh    (bus_wdata[PRIO_W-1:0]),
        .enable_q     (enable_q),
        .thresh_q     (thresh_q)
    );

    cirq_active_set #(.SLOTS(ACT_SLOTS)) u_active (
        .clk       (clk),
        .rst       (rst),
        .probe_id  (cand.id),
        .probe_hit (probe_hit),
        .claim_en  ((acc == ACC_RD_ACK) && take),
        .claim_id  (cand.id),
        .retire_en (acc == ACC_WR_RETIRE),
        .retire_id (wr_id),
        .retire_hit(retire_hit),
        .full      (slots_full)
    );

    cirq_qualify u_qual (
        .cand          (cand),
        .enable        (enable_q),
        .thresh        (thresh_q),
        .already_active(probe_hit),
        .table_full    (slots_full),
        .take          (take)
    );

    // registered outputs; read data captured at the strobe
    always_ff @(posedge clk) begin
        if (rst) begin
            bus_rdata     <= '0;
            irq_out       <= 1'b0;
            claim_valid   <= 1'b0;
            claim_id      <= '0;
            release_valid <= 1'b0;
            release_id    <= '0;
        end else begin
            irq_out       <= take;
            claim_valid   <= (acc == ACC_RD_ACK) && take;
            release_valid <= (acc == ACC_WR_RETIRE) && retire_hit;
            if ((acc == ACC_RD_ACK) && take) claim_id <= cand.id;
            if ((acc == ACC_WR_RETIRE) && retire_hit) release_id <= wr_id;
            unique case (acc)
                ACC_RD_ENABLE: bus_rdata <= BUS_W'(enable_q);
                ACC_RD_THRESH: bus_rdata <= BUS_W'(thresh_q);
                ACC_RD_ACK:    bus_rdata <= BUS_W'(take ? cand.id : NONE_ID);
                ACC_OTHER:     bus_rdata <= (bus_we) ? bus_rdata : '0;
                default:       bus_rdata <= bus_rdata;
            endcase
        end
    end

endmodule

// File: rtl/cirq_port_chk.sv
module cirq_port_chk
    import cirq_pkg::*;
#(
    parameter int ADDR_W = 2
) (
    input logic              clk,
    input logic              rst,
    input logic [7:0]        cand_prio,
    input logic              bus_en,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [31:0]       bus_rdata,
    input logic              irq_out,
    input logic              claim_valid,
    input logic [9:0]        claim_id,
    input logic              release_valid,
    input logic              enable_q,
    input logic [7:0]        thresh_q,
    input logic              slots_full
);

    // R4
    thresh_gate_chk: assert property (@(posedge clk) disable iff (rst)
        irq_out |-> ($past(cand_prio) < $past(thresh_q)));

    // R3
    enable_gate_chk: assert property (@(posedge clk) disable iff (rst)
        !enable_q |=> !irq_out);

    // R5
    claim_range_chk: assert property (@(posedge clk) disable iff (rst)
        claim_valid |-> (claim_id <= 10'd1020));

    // R1
    claim_data_chk: assert property (@(posedge clk) disable iff (rst)
        claim_valid |-> (bus_rdata == {22'd0, claim_id}));

    // R2
    claim_src_chk: assert property (@(posedge clk) disable iff (rst)
        claim_valid |-> $past(bus_en && !bus_we && bus_addr == ADDR_W'(OFF_ACK)));

    // R10
    full_block_chk: assert property (@(posedge clk) disable iff (rst)
        slots_full |=> !claim_valid);

    // R8
    release_src_chk: assert property (@(posedge clk) disable iff (rst)
        release_valid |-> $past(bus_en && bus_we && bus_addr == ADDR_W'(OFF_RETIRE)));

    // R6
    single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({claim_valid, release_valid}));

endmodule

bind cpu_irq_port cirq_port_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .cand_prio    (cand_prio),
    .bus_en       (bus_en),
    .bus_we       (bus_we),
    .bus_addr     (bus_addr),
    .bus_rdata    (bus_rdata),
    .irq_out      (irq_out),
    .claim_valid  (claim_valid),
    .claim_id     (claim_id),
    .release_valid(release_valid),
    .enable_q     (enable_q),
    .thresh_q     (thresh_q),
    .slots_full   (slots_full)
);

// File: tb/sim_cpu_irq_port.sv
module sim_cpu_irq_port;

    localparam int SLOTS = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cand_valid = 1'b0;
    logic [9:0]  cand_id = '0;
    logic [7:0]  cand_prio = '0;
    logic        bus_en = 1'b0;
    logic        bus_we = 1'b0;
    logic [1:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_out;
    logic        claim_valid;
    logic [9:0]  claim_id;
    logic        release_valid;
    logic [9:0]  release_id;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    // bench model
    logic       m_en = 1'b0;
    logic [7:0] m_thr = '0;
    logic       m_v [SLOTS];
    logic [9:0] m_id [SLOTS];

    always #4 clk = ~clk;

    cpu_irq_port #(.ADDR_W(2), .ACT_SLOTS(SLOTS)) u0 (
        .clk(clk), .rst(rst),
        .cand_valid(cand_valid), .cand_id(cand_id), .cand_prio(cand_prio),
        .bus_en(bus_en), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_out(irq_out), .claim_valid(claim_valid), .claim_id(claim_id),
        .release_valid(release_valid), .release_id(release_id)
    );

    task automatic cmp(input string tag, input string what,
                       input logic [31:0] got, input logic [31:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s %s: got %0d expected %0d", tag, what, got, exp);
        end
    endtask

    function automatic int m_count();
        int n = 0;
        for (int i = 0; i < SLOTS; i++) if (m_v[i]) n++;
        return n;
    endfunction

    function automatic logic m_has(logic [9:0] id);
        for (int i = 0; i < SLOTS; i++) if (m_v[i] && m_id[i] == id) return 1'b1;
        return 1'b0;
    endfunction

    function automatic logic m_take(logic v, logic [9:0] id, logic [7:0] p);
        return m_en && v && (id <= 10'd1020) && (p < m_thr)
            && !m_has(id) && (m_count() < SLOTS);
    endfunction

    function automatic void m_insert(logic [9:0] id);
        for (int i = 0; i < SLOTS; i++) begin
            if (!m_v[i]) begin
                m_v[i]  = 1'b1;
                m_id[i] = id;
                return;
            end
        end
    endfunction

    function automatic void m_remove(logic [9:0] id);
        for (int i = 0; i < SLOTS; i++) if (m_v[i] && m_id[i] == id) m_v[i] = 1'b0;
    endfunction

    // one bus cycle; called at a falling edge, returns at the next one
    task automatic op(input string tag, input logic en, input logic we,
                      input logic [1:0] addr, input logic [31:0] wd,
                      input logic dv, input logic [9:0] did, input logic [7:0] dp);
        logic q;
        logic hit;
        q = m_take(dv, did, dp);
        hit = m_has(wd[9:0]);
        cand_valid = dv; cand_id = did; cand_prio = dp;
        bus_en = en; bus_we = we; bus_addr = addr; bus_wdata = wd;
        @(posedge clk);
        @(negedge clk);
        bus_en = 1'b0; bus_we = 1'b0; bus_wdata = '0;
        cmp(tag, "irq_out", 32'(irq_out), 32'(q));
        if (en && !we && addr == 2'd2) begin
            cmp(tag, "ack data", bus_rdata, q ? 32'(did) : 32'd1023);
            cmp(tag, "claim_valid", 32'(claim_valid), 32'(q));
            if (q) begin
                cmp(tag, "claim_id", 32'(claim_id), 32'(did));
                m_insert(did);
            end
        end else begin
            cmp(tag, "claim_valid idle", 32'(claim_valid), 32'd0);
        end
        if (en && we && addr == 2'd3) begin
            cmp(tag, "release_valid", 32'(release_valid), 32'(hit));
            if (hit) begin
                cmp(tag, "release_id", 32'(release_id), 32'(wd[9:0]));
                m_remove(wd[9:0]);
            end
        end else begin
            cmp(tag, "release_valid idle", 32'(release_valid), 32'd0);
        end
        if (en && !we && addr == 2'd0) cmp(tag, "enable read", bus_rdata, 32'(m_en));
        if (en && !we && addr == 2'd1) cmp(tag, "thresh read", bus_rdata, 32'(m_thr));
        if (en && we && addr == 2'd0) m_en = wd[0];
        if (en && we && addr == 2'd1) m_thr = wd[7:0];
    endtask

    task automatic ack(input string tag, input logic [9:0] id, input logic [7:0] p);
        op(tag, 1'b1, 1'b0, 2'd2, 32'd0, 1'b1, id, p);
    endtask

    task automatic retire(input string tag, input logic [9:0] id);
        op(tag, 1'b1, 1'b1, 2'd3, 32'(id), cand_valid, cand_id, cand_prio);
    endtask

    task automatic wr(input string tag, input logic [1:0] a, input logic [31:0] d);
        op(tag, 1'b1, 1'b1, a, d, cand_valid, cand_id, cand_prio);
    endtask

    task automatic rd(input string tag, input logic [1:0] a);
        op(tag, 1'b1, 1'b0, a, 32'd0, cand_valid, cand_id, cand_prio);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_cmp++; n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [9:0] pool [6];
        void'($urandom(32'd20240611));
        pool[0] = 10'd5;  pool[1] = 10'd40;  pool[2] = 10'd300;
        pool[3] = 10'd1020; pool[4] = 10'd77; pool[5] = 10'd512;
        for (int i = 0; i < SLOTS; i++) begin m_v[i] = 1'b0; m_id[i] = '0; end

        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R12 reset state, R11 request low
        cmp("R11", "irq after reset", 32'(irq_out), 32'd0);
        cmp("R12", "claim after reset", 32'(claim_valid), 32'd0);
        rd("R12", 2'd0);
        rd("R12", 2'd1);
        // R4 threshold 0 masks everything
        ack("R4", 10'd40, 8'h10);
        wr("R3", 2'd0, 32'd1);
        wr("R12", 2'd1, 32'h0000_00F0);
        rd("R12", 2'd0);
        rd("R12", 2'd1);
        // R4 equal priority refused, one below accepted
        op("R4", 1'b0, 1'b0, 2'd0, 32'd0, 1'b1, 10'd40, 8'hF0);
        ack("R4", 10'd40, 8'hF0);
        op("R11", 1'b0, 1'b0, 2'd0, 32'd0, 1'b1, 10'd40, 8'hEF);
        ack("R1", 10'd40, 8'hEF);
        // R7 active id not offered again
        ack("R7", 10'd40, 8'hEF);
        // R9 completion of an inactive id
        retire("R9", 10'd41);
        ack("R9", 10'd40, 8'hEF);
        // R8 completion frees the id
        retire("R8", 10'd40);
        ack("R8", 10'd40, 8'h00);
        // R1 candidate changes right after the strobe
        op("R1", 1'b0, 1'b0, 2'd0, 32'd0, 1'b1, 10'd61, 8'h01);
        retire("R8", 10'd40);
        // R5 reserved identifiers
        ack("R5", 10'd1021, 8'h00);
        ack("R5", 10'd1022, 8'h00);
        ack("R5", 10'd1023, 8'h00);
        ack("R5", 10'd1020, 8'h00);
        retire("R5", 10'd1020);
        // R10 table full
        ack("R10", 10'd1, 8'h02);
        ack("R10", 10'd2, 8'h02);
        ack("R10", 10'd3, 8'h02);
        ack("R10", 10'd4, 8'h02);
        ack("R10", 10'd5, 8'h02);
        retire("R10", 10'd2);
        ack("R10", 10'd5, 8'h02);
        retire("R10", 10'd1);
        retire("R10", 10'd3);
        retire("R10", 10'd4);
        retire("R10", 10'd5);
        // R3 disabled, and a set bit other than bit 0
        wr("R3", 2'd0, 32'd0);
        ack("R3", 10'd9, 8'h00);
        wr("R3", 2'd0, 32'd2);
        ack("R3", 10'd9, 8'h00);
        wr("R3", 2'd0, 32'd1);
        ack("R3", 10'd9, 8'h00);
        retire("R3", 10'd9);

        // constrained random mix
        for (int k = 0; k < 4000; k++) begin
            int sel;
            logic [9:0] id;
            logic [7:0] p;
            sel = $urandom_range(0, 99);
            id  = ($urandom_range(0, 19) == 0) ? 10'(1021 + $urandom_range(0, 2))
                                               : pool[$urandom_range(0, 5)];
            p   = ($urandom_range(0, 3) == 0) ? 8'($urandom) : 8'($urandom_range(0, 8'hF8));
            if (sel < 35) begin
                ack("R2", id, p);
            end else if (sel < 60) begin
                logic [9:0] rid;
                rid = pool[$urandom_range(0, 5)];
                for (int i = 0; i < SLOTS; i++)
                    if (m_v[i] && $urandom_range(0, 1) == 1) rid = m_id[i];
                retire("R8", rid);
            end else if (sel < 66) begin
                wr("R3", 2'd0, ($urandom_range(0, 4) == 0) ? 32'd0 : 32'd1);
            end else if (sel < 72) begin
                wr("R4", 2'd1, ($urandom_range(0, 1) == 0) ? 32'h0000_00F0 : 32'($urandom_range(0, 255)));
            end else if (sel < 80) begin
                rd("R12", 2'($urandom_range(0, 1)));
            end else begin
                op("R11", 1'b0, 1'b0, 2'd0, 32'd0, $urandom_range(0, 5) != 0, id, p);
            end
        end

        if (!finished) begin
            finished = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule